// File: doc/BRIEF.md
# Modulo-Loop Branch Controller

This block resolves the closing branch of a software-pipelined loop. It keeps two counters. The trip counter holds the kernel iterations that remain. The drain counter holds the stages that must still empty after the last new iteration starts. It also owns a bank of stage predicates. Each stage of the pipelined loop body is guarded by one predicate, with the lowest bit standing for the first stage.

Each loop-branch strobe does three things. It decides whether the branch is taken. It counts the relevant counter down. It emits a rotate pulse that the register-file rename base follows. On a rotation the predicate bank shifts up by one, and a fresh value enters the lowest stage: 1 while new iterations are being started, 0 while the pipeline drains.

A host loads both counters before the loop is entered. A load always wins over a branch strobe that arrives in the same cycle.

Top module: `loopbr_ctrl`

## Requirements
- R1: After reset the stage predicates are all 0 and both counters are 0, so `br_taken` and `rot_strobe` stay 0 even when a branch strobe arrives.
- R2: A branch strobe while the trip counter is non-zero is taken, pulses `rot_strobe`, decrements the trip counter, and shifts a 1 into `stage_pred[0]`.
- R3: A branch strobe while the trip counter is 0 and the drain counter is greater than 1 is taken, pulses `rot_strobe`, decrements the drain counter, and shifts a 0 into `stage_pred[0]`.
- R4: A branch strobe while the trip counter is 0 and the drain counter is exactly 1 falls through (`br_taken` = 0). It still pulses `rot_strobe`, shifts a 0 into `stage_pred[0]`, and leaves the drain counter at 0.
- R5: A branch strobe while both counters are 0 falls through, gives no rotate pulse, and leaves `stage_pred` unchanged.
- R6: On every rotation, `stage_pred[i]` takes the previous `stage_pred[i-1]` for i ≥ 1, and the previous top bit is discarded. The new vector is visible from the clock edge that ends the strobe cycle.
- R7: When `trip_ld` or `drain_ld` is high, a branch strobe in the same cycle is ignored: no taken, no rotate, and the predicates are unchanged. Only the counter(s) whose load is high take the new value at that edge.
- R8: `br_taken` and `rot_strobe` depend combinationally on the current cycle's inputs. They are 0 in any cycle without a branch strobe.
- R9: After loading trip = 4 and drain = 3, seven consecutive strobes rotate seven times. The first six are taken and the seventh falls through. An eighth strobe rotates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_exec | input | 1 | A loop-branch executes this cycle |
| trip_ld | input | 1 | Load the trip counter |
| trip_val | input | CNT_W | Trip counter load value |
| drain_ld | input | 1 | Load the drain counter |
| drain_val | input | DRN_W | Drain counter load value |
| br_taken | output | 1 | Branch taken (same cycle as strobe) |
| rot_strobe | output | 1 | Rotate the register base down by one (same cycle as strobe) |
| stage_pred | output | NUM_PRED | Stage predicates; bit 0 is the first stage |

## Verification
`br_taken` and `rot_strobe` are due in the same cycle as the strobe. The predicate vector and the counters change at the next rising edge. The bench drives inputs just after a falling edge and compares the two pulses one nanosecond later, before the rising edge. At that same point it compares `stage_pred` with the model's state, which the model has advanced only at the previous edge. Counter values are checked indirectly, through the taken and fall-through decisions of later strobes.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;
    // Action chosen for the current cycle
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_KERNEL = 3'd2,
        ACT_DRAIN  = 3'd3,
        ACT_EXIT   = 3'd4
    } loop_act_e;
endpackage

// File: rtl/loopbr_decide.sv
module loopbr_decide
    import loopbr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DRN_W = 8
) (
    input  logic             br_exec,
    input  logic             trip_ld,
    input  logic             drain_ld,
    input  logic [CNT_W-1:0] trip_q,
    input  logic [DRN_W-1:0] drain_q,
    output loop_act_e        act,
    output logic             taken,
    output logic             rotate,
    output logic             inject
);
    localparam logic [DRN_W-1:0] DRN_ONE = DRN_W'(1);

    always_comb begin
        act = ACT_NONE;
        if (trip_ld || drain_ld) begin
            act = ACT_LOAD;
        end else if (br_exec) begin
            if (trip_q != '0)            act = ACT_KERNEL;
            else if (drain_q > DRN_ONE)  act = ACT_DRAIN;
            else if (drain_q == DRN_ONE) act = ACT_EXIT;
        end
        taken  = (act == ACT_KERNEL) || (act == ACT_DRAIN);
        rotate = taken || (act == ACT_EXIT);
        inject = (act == ACT_KERNEL);
    end
endmodule

// File: rtl/loopbr_counters.sv
module loopbr_counters
    import loopbr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DRN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  loop_act_e        act,
    input  logic             trip_ld,
    input  logic [CNT_W-1:0] trip_val,
    input  logic             drain_ld,
    input  logic [DRN_W-1:0] drain_val,
    output logic [CNT_W-1:0] trip_q,
    output logic [DRN_W-1:0] drain_q
);
    typedef struct packed {
        logic [CNT_W-1:0] trip;
        logic [DRN_W-1:0] drain;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_LOAD: begin
                if (trip_ld)  cnt_d.trip  = trip_val;
                if (drain_ld) cnt_d.drain = drain_val;
            end
            ACT_KERNEL: cnt_d.trip  = cnt_q.trip - CNT_W'(1);
            ACT_DRAIN:  cnt_d.drain = cnt_q.drain - DRN_W'(1);
            ACT_EXIT:   cnt_d.drain = '0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip_q  = cnt_q.trip;
    assign drain_q = cnt_q.drain;
endmodule

// File: rtl/loopbr_pred_rot.sv
module loopbr_pred_rot #(
    parameter int NUM_PRED = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rotate,
    input  logic                inject,
    output logic [NUM_PRED-1:0] pred_q
);
    logic [NUM_PRED-1:0] shifted;
    logic [NUM_PRED-1:0] pred_d;

    for (genvar i = 0; i < NUM_PRED; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign shifted[i] = inject;
        end else begin : g_body
            assign shifted[i] = pred_q[i-1];
        end
    end

    always_comb begin
        pred_d = rotate ? shifted : pred_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pred_q <= '0;
        else        pred_q <= pred_d;
    end
endmodule

// File: rtl/loopbr_ctrl.sv
module loopbr_ctrl
    import loopbr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DRN_W    = 8,
    parameter int NUM_PRED = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_exec,
    input  logic                trip_ld,
    input  logic [CNT_W-1:0]    trip_val,
    input  logic                drain_ld,
    input  logic [DRN_W-1:0]    drain_val,
    output logic                br_taken,
    output logic                rot_strobe,
    output logic [NUM_PRED-1:0] stage_pred
);
    loop_act_e        act;
    logic             inject;
    logic [CNT_W-1:0] trip_q;
    logic [DRN_W-1:0] drain_q;

    loopbr_decide #(.CNT_W(CNT_W), .DRN_W(DRN_W)) u_decide (
        .br_exec (br_exec),
        .trip_ld (trip_ld),
        .drain_ld(drain_ld),
        .trip_q  (trip_q),
        .drain_q (drain_q),
        .act     (act),
        .taken   (br_taken),
        .rotate  (rot_strobe),
        .inject  (inject)
    );

    loopbr_counters #(.CNT_W(CNT_W), .DRN_W(DRN_W)) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .trip_ld  (trip_ld),
        .trip_val (trip_val),
        .drain_ld (drain_ld),
        .drain_val(drain_val),
        .trip_q   (trip_q),
        .drain_q  (drain_q)
    );

    loopbr_pred_rot #(.NUM_PRED(NUM_PRED)) u_pred (
        .clk   (clk),
        .rst_n (rst_n),
        .rotate(rot_strobe),
        .inject(inject),
        .pred_q(stage_pred)
    );
endmodule

// File: rtl/loopbr_ctrl_chk.sv
module loopbr_ctrl_chk #(
    parameter int CNT_W    = 16,
    parameter int DRN_W    = 8,
    parameter int NUM_PRED = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                br_exec,
    input logic                trip_ld,
    input logic                drain_ld,
    input logic                br_taken,
    input logic                rot_strobe,
    input logic [NUM_PRED-1:0] stage_pred,
    input logic [CNT_W-1:0]    trip_q,
    input logic [DRN_W-1:0]    drain_q
);
    a_r8_rot_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        rot_strobe |-> br_exec);

    a_r2_taken_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> rot_strobe);

    a_r7_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_ld || drain_ld) |-> !rot_strobe);

    a_r6_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        rot_strobe |=> stage_pred[NUM_PRED-1:1] == $past(stage_pred[NUM_PRED-2:0]));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rot_strobe |=> $stable(stage_pred));

    a_r2_inject_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_strobe && trip_q != '0) |=> stage_pred[0]);

    a_r3_inject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_strobe && trip_q == '0) |=> !stage_pred[0]);

    a_r4_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_strobe && !br_taken) |=> drain_q == '0);
endmodule

bind loopbr_ctrl loopbr_ctrl_chk #(
    .CNT_W(CNT_W), .DRN_W(DRN_W), .NUM_PRED(NUM_PRED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_exec   (br_exec),
    .trip_ld   (trip_ld),
    .drain_ld  (drain_ld),
    .br_taken  (br_taken),
    .rot_strobe(rot_strobe),
    .stage_pred(stage_pred),
    .trip_q    (trip_q),
    .drain_q   (drain_q)
);

// File: tb/loopbr_ctrl_bench.sv
`timescale 1ns/1ps
module loopbr_ctrl_bench;
    localparam int CNT_W = 16;
    localparam int DRN_W = 8;
    localparam int NP    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_exec = 1'b0;
    logic          trip_ld = 1'b0;
    logic [CNT_W-1:0] trip_val = '0;
    logic          drain_ld = 1'b0;
    logic [DRN_W-1:0] drain_val = '0;
    logic          br_taken;
    logic          rot_strobe;
    logic [NP-1:0] stage_pred;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int            m_trip = 0;
    int            m_drain = 0;
    logic [NP-1:0] m_pred = '0;

    always #2.5 clk = ~clk;

    loopbr_ctrl #(.CNT_W(CNT_W), .DRN_W(DRN_W), .NUM_PRED(NP)) u_loopbr_ctrl (
        .clk(clk), .rst_n(rst_n), .br_exec(br_exec),
        .trip_ld(trip_ld), .trip_val(trip_val),
        .drain_ld(drain_ld), .drain_val(drain_val),
        .br_taken(br_taken), .rot_strobe(rot_strobe), .stage_pred(stage_pred)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after falling edge, compare before rising edge, advance model
    task automatic step(input logic br, input logic tl, input int tv,
                        input logic dl, input int dv, input string tag);
        logic ld, exp_taken, exp_rot;
        @(negedge clk);
        br_exec = br; trip_ld = tl; trip_val = CNT_W'(tv);
        drain_ld = dl; drain_val = DRN_W'(dv);
        #1;
        ld        = tl || dl;
        exp_taken = br && !ld && (m_trip > 0 || m_drain > 1);
        exp_rot   = br && !ld && (m_trip > 0 || m_drain > 0);
        check(tag, "br_taken", int'(br_taken), int'(exp_taken));
        check(tag, "rot_strobe", int'(rot_strobe), int'(exp_rot));
        check(tag, "stage_pred", int'(stage_pred), int'(m_pred));
        @(posedge clk);
        if (ld) begin
            if (tl) m_trip = tv;
            if (dl) m_drain = dv;
        end else if (br) begin
            if (m_trip > 0) begin
                m_trip--;
                m_pred = {m_pred[NP-2:0], 1'b1};
            end else if (m_drain > 0) begin
                m_drain--;
                m_pred = {m_pred[NP-2:0], 1'b0};
            end
        end
    endtask

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, strobe with empty counters
        step(0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, "R1");
        // R9: trip 4, drain 3 -> seven rotations, six taken
        step(0, 1, 4, 1, 3, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R9");
        // R5: both counters zero
        step(1, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R5");
        // R8: no strobe while trip counter loaded
        step(0, 1, 2, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        // R7: load collides with strobe
        step(1, 1, 11, 0, 0, "R7");
        step(1, 0, 0, 1, 6, "R7");
        step(0, 0, 0, 0, 0, "R7");
        // R6: long kernel fills and overflows the bank
        for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 0, "R6");
        // R3 drain then R4 exit
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R5");
        // R4: drain of exactly one straight away
        step(0, 0, 0, 1, 1, "R4");
        step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R6");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule